// File: doc/BRIEF.md
# 32-Pin GPIO Bank with Edge Interrupt and Wakeup Detection

This block controls one bank of general-purpose pins. Software reaches it through a simple single-cycle register bus. Through that bus it drives output levels, chooses the direction of each pin and routes each pin either to software control or to one of three peripheral functions in an external pin multiplexer. Output levels and directions each have a plain write register plus a set register and a clear register. A bit can therefore be changed without a read-modify-write sequence.

Raw pin levels pass through a two-stage synchronizer. From there they are read back through the bus and checked for rising and falling edges. Each edge direction has its own enable mask for the interrupt path and its own mask for the wakeup path. An enabled edge sets a sticky status bit. Software clears a status bit by writing one to it. The interrupt output and the wakeup output are each the OR of their own status word.

Register map (byte offsets, 32-bit words):

| Offset | Name | Behaviour |
|---|---|---|
| 0x00 | level / output | Read returns the synchronized pin levels. Write loads the whole output latch. |
| 0x04 | output set | Writing ones sets bits of the output latch. Read returns the latch. |
| 0x08 | output clear | Writing ones clears bits of the output latch. Read returns the latch. |
| 0x0C | direction | Read/write. 1 means output. |
| 0x10 | direction set | Writing ones sets direction bits. Read returns the direction register. |
| 0x14 | direction clear | Writing ones clears direction bits. Read returns the direction register. |
| 0x18 | function low | Read/write. Bit 0 of each pin's function code. |
| 0x1C | function high | Read/write. Bit 1 of each pin's function code. |
| 0x20 | rise irq enable | Read/write. |
| 0x24 | fall irq enable | Read/write. |
| 0x28 | irq status | Read-only. |
| 0x2C | irq clear | Write-one-to-clear. Reads 0. |
| 0x30 | rise wake enable | Read/write. |
| 0x34 | fall wake enable | Read/write. |
| 0x38 | wake status | Read-only. |
| 0x3C | wake clear | Write-one-to-clear. Reads 0. |

Top module: `gpio_bank`

## Requirements
- R1: While reset is applied, and during the two cycles in which the internal reset is released, every register reads 0, and the pin output, output enable, function select, irq_o and wake_o outputs are all 0.
- R2: A write to 0x00 loads the output latch. Writing ones to 0x04 sets latch bits, and writing ones to 0x08 clears them. Zero bits leave their latch bits unchanged. Both 0x04 and 0x08 read back the latch. pin_out shows the latch from the cycle after the write.
- R3: The direction register at 0x0C has a set register at 0x10 and a clear register at 0x14, with the same semantics as R2. All three offsets read back the direction register.
- R4: Pin i has the function code {bit i of 0x1C, bit i of 0x18}, which appears at pin_fsel[2i+1:2i]. The codes are 00 = software GPIO, 01 = function A, 10 = function B, 11 = function C.
- R5: pin_oe[i] is 1 only when direction bit i is 1 and the function code of pin i is 00.
- R6: A read of 0x00 returns the pin levels as they were two clock edges earlier: the first edge captures the level and the second edge makes it visible.
- R7: A rising edge of a synchronized level, with its bit set in 0x20, sets the matching bit of the irq status at 0x28. A falling edge with its bit set in 0x24 does the same. A pin enabled in both registers triggers on both edges. The status bit is set at the third clock edge after the pin changes.
- R8: irq status bits are sticky. Writing ones to 0x2C clears them. If an enabled edge and a clear for the same bit occur in the same cycle, the bit stays set. Clearing a mask bit does not clear a status bit that is already set.
- R9: irq_o is 1 exactly when any irq status bit is 1. wake_o is 1 exactly when any wake status bit is 1.
- R10: Wake status bits at 0x38 are set only by edges enabled in 0x30 (rising) and 0x34 (falling), with no dependence on the irq enables. Writing ones to 0x3C clears them, under the same collision rule as R8.
- R11: Writes to read-only or unmapped offsets change nothing. Reads of unmapped offsets, and of 0x2C and 0x3C, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, available in the same cycle |
| pin_i | input | 32 | Raw pin levels, asynchronous to clk |
| pin_out | output | 32 | Output level for each pin |
| pin_oe | output | 32 | Output enable for each pin |
| pin_fsel | output | 64 | Two-bit function code for each pin, sent to the external mux |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
A wrong bit in a control register shows up on pin_out, pin_oe or pin_fsel in the cycle after the write. A wrong bit in the synchronizer or the edge history shows up as a wrong level read at 0x00, or as a status bit that is set one cycle early or late. Status and irq_o/wake_o are compared against the reference on every cycle while pins toggle, so a lost or spurious edge is caught at the edge on which the status bit should have changed. The clear-and-edge collision and the independence of the wake path from the irq path are each driven on purpose, and again by random bus traffic.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam logic [7:0] OFS_LEVEL     = 8'h00;
  localparam logic [7:0] OFS_OUT_SET   = 8'h04;
  localparam logic [7:0] OFS_OUT_CLR   = 8'h08;
  localparam logic [7:0] OFS_DIR       = 8'h0C;
  localparam logic [7:0] OFS_DIR_SET   = 8'h10;
  localparam logic [7:0] OFS_DIR_CLR   = 8'h14;
  localparam logic [7:0] OFS_FN_LO     = 8'h18;
  localparam logic [7:0] OFS_FN_HI     = 8'h1C;
  localparam logic [7:0] OFS_RISE_IEN  = 8'h20;
  localparam logic [7:0] OFS_FALL_IEN  = 8'h24;
  localparam logic [7:0] OFS_IRQ_STAT  = 8'h28;
  localparam logic [7:0] OFS_IRQ_CLR   = 8'h2C;
  localparam logic [7:0] OFS_RISE_WEN  = 8'h30;
  localparam logic [7:0] OFS_FALL_WEN  = 8'h34;
  localparam logic [7:0] OFS_WAKE_STAT = 8'h38;
  localparam logic [7:0] OFS_WAKE_CLR  = 8'h3C;

  // plain configuration words held in one array
  localparam int NCFG = 6;
  typedef enum int {
    CFG_FN_LO    = 0,
    CFG_FN_HI    = 1,
    CFG_RISE_IEN = 2,
    CFG_FALL_IEN = 3,
    CFG_RISE_WEN = 4,
    CFG_FALL_WEN = 5
  } cfg_idx_e;

  typedef enum logic [1:0] {
    FN_SOFT = 2'b00,
    FN_A    = 2'b01,
    FN_B    = 2'b10,
    FN_C    = 2'b11
  } fn_code_e;

  function automatic logic [7:0] cfg_offset(input int k);
    case (k)
      CFG_FN_LO:    cfg_offset = OFS_FN_LO;
      CFG_FN_HI:    cfg_offset = OFS_FN_HI;
      CFG_RISE_IEN: cfg_offset = OFS_RISE_IEN;
      CFG_FALL_IEN: cfg_offset = OFS_FALL_IEN;
      CFG_RISE_WEN: cfg_offset = OFS_RISE_WEN;
      default:      cfg_offset = OFS_FALL_WEN;
    endcase
  endfunction

endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;
  logic         upd_en;

  always_comb begin
    q_d = q;
    if (load_en)     q_d = wdata;
    else if (set_en) q_d = q | wdata;
    else if (clr_en) q_d = q & ~wdata;
  end

  assign upd_en = load_en | set_en | clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (upd_en) q <= q_d;
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & $past(wdata)) == $past(wdata))); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q & $past(wdata)) == '0)); // R2
  AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en || clr_en) |=> (((q ^ $past(q)) & ~$past(wdata)) == '0)); // R3

endmodule

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  localparam int NSTG = 2;

  logic [W-1:0] stg_q [NSTG];
  logic [W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSTG; s++) stg_q[s] <= '0;
      last_q <= '0;
    end else begin
      stg_q[0] <= pin_raw;
      for (int s = 1; s < NSTG; s++) stg_q[s] <= stg_q[s-1];
      last_q <= stg_q[NSTG-1];
    end
  end

  assign lvl_o  = stg_q[NSTG-1];
  assign rise_o = lvl_o & ~last_q;
  assign fall_o = ~lvl_o & last_q;

  AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_o) |=> ((($past(rise_o)) & ~last_q) == '0)); // R7
  AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall_o) |=> ((($past(fall_o)) & last_q) == '0)); // R7

endmodule

// File: rtl/gpio_sticky_status.sv
module gpio_sticky_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stat_o
);

  logic [W-1:0] clr_bits;
  logic [W-1:0] stat_d;

  always_comb begin
    clr_bits = clr_en ? clr_mask : '0;
    // a new event wins over a clear of the same bit
    stat_d   = (stat_o & ~clr_bits) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_o <= '0;
    else        stat_o <= stat_d;
  end

  AST_STAT_ONLY_FROM_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(evt_i)) == '0)); // R7
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_o) & ~stat_o & ~$past(clr_bits)) == '0)); // R8
  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_o & $past(evt_i)) == $past(evt_i))); // R8

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [2*NPIN-1:0] pin_fsel,
  output logic              irq_o,
  output logic              wake_o
);

  localparam int FW = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // address decode
  logic hit_level, hit_out_set, hit_out_clr;
  logic hit_dir, hit_dir_set, hit_dir_clr;
  logic hit_irq_clr, hit_wake_clr;

  always_comb begin
    hit_level    = bus_addr == AW'(OFS_LEVEL);
    hit_out_set  = bus_addr == AW'(OFS_OUT_SET);
    hit_out_clr  = bus_addr == AW'(OFS_OUT_CLR);
    hit_dir      = bus_addr == AW'(OFS_DIR);
    hit_dir_set  = bus_addr == AW'(OFS_DIR_SET);
    hit_dir_clr  = bus_addr == AW'(OFS_DIR_CLR);
    hit_irq_clr  = bus_addr == AW'(OFS_IRQ_CLR);
    hit_wake_clr = bus_addr == AW'(OFS_WAKE_CLR);
  end

  // output latch and direction
  logic [NPIN-1:0] out_q, dir_q;

  gpio_setclr_reg #(.W(NPIN)) u_out (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_en(bus_wr & hit_level),
    .set_en (bus_wr & hit_out_set),
    .clr_en (bus_wr & hit_out_clr),
    .wdata  (bus_wdata),
    .q      (out_q)
  );

  gpio_setclr_reg #(.W(NPIN)) u_dir (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_en(bus_wr & hit_dir),
    .set_en (bus_wr & hit_dir_set),
    .clr_en (bus_wr & hit_dir_clr),
    .wdata  (bus_wdata),
    .q      (dir_q)
  );

  // plain configuration words
  logic [NPIN-1:0] cfg_q [NCFG];
  logic [NPIN-1:0] cfg_d [NCFG];
  logic [NCFG-1:0] cfg_we;

  always_comb begin
    for (int k = 0; k < NCFG; k++) begin
      cfg_we[k] = bus_wr && (bus_addr == AW'(cfg_offset(k)));
      cfg_d[k]  = cfg_we[k] ? bus_wdata : cfg_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int k = 0; k < NCFG; k++) cfg_q[k] <= '0;
    end else begin
      for (int k = 0; k < NCFG; k++)
        if (cfg_we[k]) cfg_q[k] <= cfg_d[k];
    end
  end

  // input path
  logic [NPIN-1:0] lvl, rise, fall;

  gpio_sync_edge #(.W(NPIN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_raw(pin_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  logic [NPIN-1:0] irq_evt, wake_evt, irq_stat, wake_stat;

  assign irq_evt  = (rise & cfg_q[CFG_RISE_IEN]) | (fall & cfg_q[CFG_FALL_IEN]);
  assign wake_evt = (rise & cfg_q[CFG_RISE_WEN]) | (fall & cfg_q[CFG_FALL_WEN]);

  gpio_sticky_status #(.W(NPIN)) u_irq_stat (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .evt_i   (irq_evt),
    .clr_en  (bus_wr & hit_irq_clr),
    .clr_mask(bus_wdata),
    .stat_o  (irq_stat)
  );

  gpio_sticky_status #(.W(NPIN)) u_wake_stat (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .evt_i   (wake_evt),
    .clr_en  (bus_wr & hit_wake_clr),
    .clr_mask(bus_wdata),
    .stat_o  (wake_stat)
  );

  // pin-side outputs
  logic [NPIN-1:0] soft_mode;

  assign soft_mode = ~(cfg_q[CFG_FN_LO] | cfg_q[CFG_FN_HI]);
  assign pin_out   = out_q;
  assign pin_oe    = dir_q & soft_mode;
  assign irq_o     = |irq_stat;
  assign wake_o    = |wake_stat;

  for (genvar i = 0; i < NPIN; i++) begin : g_fsel
    assign pin_fsel[FW*i +: FW] = {cfg_q[CFG_FN_HI][i], cfg_q[CFG_FN_LO][i]};
  end

  // read mux
  always_comb begin
    case (bus_addr)
      AW'(OFS_LEVEL):     bus_rdata = lvl;
      AW'(OFS_OUT_SET),
      AW'(OFS_OUT_CLR):   bus_rdata = out_q;
      AW'(OFS_DIR),
      AW'(OFS_DIR_SET),
      AW'(OFS_DIR_CLR):   bus_rdata = dir_q;
      AW'(OFS_FN_LO):     bus_rdata = cfg_q[CFG_FN_LO];
      AW'(OFS_FN_HI):     bus_rdata = cfg_q[CFG_FN_HI];
      AW'(OFS_RISE_IEN):  bus_rdata = cfg_q[CFG_RISE_IEN];
      AW'(OFS_FALL_IEN):  bus_rdata = cfg_q[CFG_FALL_IEN];
      AW'(OFS_IRQ_STAT):  bus_rdata = irq_stat;
      AW'(OFS_RISE_WEN):  bus_rdata = cfg_q[CFG_RISE_WEN];
      AW'(OFS_FALL_WEN):  bus_rdata = cfg_q[CFG_FALL_WEN];
      AW'(OFS_WAKE_STAT): bus_rdata = wake_stat;
      default:            bus_rdata = '0;
    endcase
  end

  AST_OE_SOFT_ONLY: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((pin_oe & (cfg_q[CFG_FN_LO] | cfg_q[CFG_FN_HI])) == '0)); // R5
  AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((pin_oe & ~dir_q) == '0)); // R5
  AST_IRQ_DROPS_ON_CLR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && hit_irq_clr && (bus_wdata == '1) && !(|irq_evt)) |=> !irq_o); // R9
  AST_WAKE_DROPS_ON_CLR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && hit_wake_clr && (bus_wdata == '1) && !(|wake_evt)) |=> !wake_o); // R10

endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [7:0]    bus_addr;
  logic [NP-1:0] bus_wdata;
  logic [NP-1:0] bus_rdata;
  logic [NP-1:0] pin_i;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic [2*NP-1:0] pin_fsel;
  logic          irq_o;
  logic          wake_o;

  gpio_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_fsel(pin_fsel),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string phase = "R1";

  // behavioural reference state
  logic [NP-1:0] m_out, m_dir, m_flo, m_fhi, m_rie, m_fie, m_rwe, m_fwe;
  logic [NP-1:0] m_ist, m_wst;
  logic [NP-1:0] m_seen [$];
  int            m_hold;

  task automatic m_clear();
    m_out = '0; m_dir = '0; m_flo = '0; m_fhi = '0;
    m_rie = '0; m_fie = '0; m_rwe = '0; m_fwe = '0;
    m_ist = '0; m_wst = '0;
    m_seen = {32'h0, 32'h0, 32'h0};
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_clear();
      m_hold = 2;
    end else if (m_hold > 0) begin
      m_hold = m_hold - 1;
    end else begin
      logic [NP-1:0] up, dn, ievt, wevt, iclr, wclr;
      up   = m_seen[1] & ~m_seen[2];
      dn   = ~m_seen[1] & m_seen[2];
      ievt = (up & m_rie) | (dn & m_fie);
      wevt = (up & m_rwe) | (dn & m_fwe);
      iclr = (bus_wr && bus_addr == 8'h2C) ? bus_wdata : '0;
      wclr = (bus_wr && bus_addr == 8'h3C) ? bus_wdata : '0;
      m_ist = (m_ist & ~iclr) | ievt;
      m_wst = (m_wst & ~wclr) | wevt;
      if (bus_wr) begin
        case (bus_addr)
          8'h00: m_out = bus_wdata;
          8'h04: m_out = m_out | bus_wdata;
          8'h08: m_out = m_out & ~bus_wdata;
          8'h0C: m_dir = bus_wdata;
          8'h10: m_dir = m_dir | bus_wdata;
          8'h14: m_dir = m_dir & ~bus_wdata;
          8'h18: m_flo = bus_wdata;
          8'h1C: m_fhi = bus_wdata;
          8'h20: m_rie = bus_wdata;
          8'h24: m_fie = bus_wdata;
          8'h30: m_rwe = bus_wdata;
          8'h34: m_fwe = bus_wdata;
          default: ;
        endcase
      end
      m_seen.push_front(pin_i);
      void'(m_seen.pop_back());
    end
  end

  function automatic logic [NP-1:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return m_seen[1];
      8'h04, 8'h08: return m_out;
      8'h0C, 8'h10, 8'h14: return m_dir;
      8'h18: return m_flo;
      8'h1C: return m_fhi;
      8'h20: return m_rie;
      8'h24: return m_fie;
      8'h28: return m_ist;
      8'h30: return m_rwe;
      8'h34: return m_fwe;
      8'h38: return m_wst;
      default: return '0;
    endcase
  endfunction

  function automatic logic [2*NP-1:0] exp_fsel();
    logic [2*NP-1:0] f;
    for (int i = 0; i < NP; i++) f[2*i +: 2] = {m_fhi[i], m_flo[i]};
    return f;
  endfunction

  task automatic chk64(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s t=%0t actual=%h expected=%h", phase, what, $time, act, exp);
    end
  endtask

  // compare on every falling edge, before new stimulus is driven
  always @(negedge clk) begin
    if (!done) begin
      chk64("rdata", 64'(bus_rdata), 64'(exp_rd(bus_addr)));
      chk64("pin_out", 64'(pin_out), 64'(m_out));
      chk64("pin_oe", 64'(pin_oe), 64'(m_dir & ~(m_flo | m_fhi)));
      chk64("pin_fsel", pin_fsel, exp_fsel());
      chk64("irq_o", 64'(irq_o), 64'(|m_ist));
      chk64("wake_o", 64'(wake_o), 64'(|m_wst));
    end
  end

  task automatic idle(input logic [7:0] a, input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      bus_wr = 1'b0; bus_addr = a;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [NP-1:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic pins(input logic [NP-1:0] v);
    @(negedge clk); #1;
    pin_i = v;
  endtask

  task automatic sweep();
    for (int a = 0; a < 16; a++) idle(8'(a*4));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired in %s", phase);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_i = '0;
    // R1: reset and release window
    idle(8'h00, 3);
    @(negedge clk); #1; rst_n = 1'b1;
    sweep();

    phase = "R2";
    wr(8'h00, 32'hA5A5_0F0F); idle(8'h04, 2);
    wr(8'h04, 32'h0000_F0F0); idle(8'h08, 2);
    wr(8'h08, 32'h0F00_0001); idle(8'h00, 1); idle(8'h04, 1);

    phase = "R3";
    wr(8'h0C, 32'h00FF_00FF); idle(8'h10, 1);
    wr(8'h10, 32'hF000_0000); idle(8'h14, 1);
    wr(8'h14, 32'h0000_0011); idle(8'h0C, 1);

    phase = "R4";
    wr(8'h18, 32'h0000_00F0); wr(8'h1C, 32'h0000_0F30); sweep();
    phase = "R5";
    wr(8'h10, 32'hFFFF_FFFF); idle(8'h0C, 2);
    wr(8'h18, 32'h0); wr(8'h1C, 32'h8000_0000); idle(8'h1C, 2);

    phase = "R6";
    pins(32'h1234_5678); idle(8'h00, 4);
    pins(32'h0); idle(8'h00, 4);

    phase = "R7";
    wr(8'h20, 32'h0000_000F); wr(8'h24, 32'h0000_0F03);
    pins(32'h0000_00FF); idle(8'h28, 5);
    pins(32'h0000_0000); idle(8'h28, 5);
    phase = "R9";
    wr(8'h2C, 32'hFFFF_FFFF); idle(8'h28, 3);

    phase = "R8";
    pins(32'h0000_0001); idle(8'h28, 5);
    wr(8'h20, 32'h0); idle(8'h28, 2);          // mask cleared, status kept
    wr(8'h20, 32'h0000_0002);
    pins(32'h0000_0003); idle(8'h28, 1);        // rise on pin 1 lands on the clear cycle
    wr(8'h2C, 32'h0000_0003); idle(8'h28, 3);
    wr(8'h2C, 32'hFFFF_FFFF); idle(8'h28, 2);

    phase = "R10";
    wr(8'h20, 32'h0); wr(8'h24, 32'h0);
    wr(8'h30, 32'h0000_F000); wr(8'h34, 32'h00F0_0000);
    pins(32'h00F0_F000); idle(8'h38, 5);
    pins(32'h0000_0000); idle(8'h38, 5);
    idle(8'h28, 1);
    wr(8'h3C, 32'h0000_F000); idle(8'h38, 2);
    wr(8'h3C, 32'hFFFF_FFFF); idle(8'h38, 2);

    phase = "R11";
    wr(8'h28, 32'hFFFF_FFFF); wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h7C, 32'hFFFF_FFFF); wr(8'h02, 32'hFFFF_FFFF);
    sweep(); idle(8'h40, 1); idle(8'h7C, 1); idle(8'hFF, 1);

    phase = "R7-mix";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); #1;
      if ($urandom_range(0, 3) == 0) pin_i = $urandom;
      bus_wr    = ($urandom_range(0, 2) == 0);
      bus_addr  = 8'($urandom_range(0, 16) * 4);
      bus_wdata = $urandom;
    end
    idle(8'h28, 1);

    phase = "R1-again";
    @(negedge clk); #1; rst_n = 1'b0;
    idle(8'h00, 2);
    @(negedge clk); #1; rst_n = 1'b1;
    sweep();

    finish_run();
  end

endmodule